// File: doc/BRIEF.md
# Dual-Channel Edge Capture Controller

This block watches two external capture pins and, on each one, detects the kind of transition that software has chosen. When a chosen transition arrives, it copies the value of a free-running timer into that channel's capture register. It also sets a sticky request flag and, if that channel is enabled, raises the channel's interrupt line. The timer itself and the interrupt controller are outside the block. More than two channels are built by instantiating the block several times.

Software controls the block through one byte-wide control/status register on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. A qualifier marks the read half of a read-modify-write access. During such a read the request flags read back as 1, so the write-back that follows cannot erase a pending request. A request flag is cleared only by writing 0 to it. If hardware sets a flag in the same cycle that software clears it, the flag stays set.

No port carries a stream, so there is no valid/ready handshake and no back-pressure. The capture registers are plain outputs, and a new capture simply overwrites the held value.

Top module: `edge_capture_pair`

## Requirements
- R1: After reset, the control byte reads 0x00, both interrupt outputs are low and both capture registers hold 0.
- R2: With edge mode 01, a channel flags and captures on a low-to-high pin transition only. A high-to-low transition leaves both the flag and the capture register unchanged.
- R3: With edge mode 10, a channel flags and captures on a high-to-low transition only.
- R4: With edge mode 11, a channel flags and captures on both transitions.
- R5: With edge mode 00, a channel never sets its flag and never updates its capture register.
- R6: On a detected edge, the timer value present in that cycle is stored in the channel's capture register at the same clock edge that sets the flag. A later edge overwrites the stored value even while the flag is still pending.
- R7: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit has no effect.
- R8: The control byte, from bit 7 down to bit 0, holds: the channel-1 flag, the channel-0 flag, the channel-1 enable, the channel-0 enable, the channel-1 edge mode [3:2] and the channel-0 edge mode [1:0]. The enable and mode fields read back exactly what was written.
- R9: When an edge detection and a software write of 0 to the same flag fall in the same cycle, the flag is 1 afterwards.
- R10: A read with `reg_rmw` high returns 1 in both flag bits. A read with `reg_rmw` low returns the true flag values.
- R11: A channel's interrupt output is high exactly while both its flag and its enable are 1. An enable of 0 does not stop the flag from being set.
- R12: A pin transition that is sampled at clock edge k shows in the flag after clock edge k+2 and not before. Reprogramming an edge mode while the pin is steady never sets a flag.
- R13: Writes to any address other than `CTRL_ADDR` change nothing, and reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rmw | input | 1 | Marks the read half of a read-modify-write access |
| reg_rdata | output | 8 | Combinational read data |
| cap_pin | input | 2 | Asynchronous capture pins, one bit per channel |
| timer_val | input | TIMER_W | Free-running timer value |
| cap_data0 | output | TIMER_W | Channel-0 capture register |
| cap_data1 | output | TIMER_W | Channel-1 capture register |
| irq | output | 2 | Interrupt outputs, one bit per channel |

## Verification
The bench builds the block with its defaults: a 16-bit timer, a two-flop synchronizer, a 4-bit address and the control register at address 0. Two flops fix the pin-to-flag delay at three clock edges, so the bench can sample the cycle before and the cycle after the flag rises. It can also place a software clear exactly on the clock edge where a flag is set. The 4-bit address leaves room for a second, unused address, which exercises the decode and the zero read-back.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Bit order of the control byte, most significant first.
  typedef struct packed {
    logic [1:0] flag;   // [7] channel 1, [6] channel 0
    logic [1:0] en;     // [5] channel 1, [4] channel 0
    edge_mode_e mode1;  // [3:2]
    edge_mode_e mode0;  // [1:0]
  } ctrl_byte_t;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/ecp_pin_sync.sv
module ecp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic level_d
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

endmodule

// File: rtl/ecp_edge_detect.sv
module ecp_edge_detect
  import ecp_pkg::*;
(
  input  logic       level,
  input  logic       level_d,
  input  edge_mode_e mode,
  output logic       hit
);

  logic went_up;
  logic went_down;

  assign went_up   = level & ~level_d;
  assign went_down = ~level & level_d;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = went_up;
      EDGE_FALL: hit = went_down;
      EDGE_ANY:  hit = went_up | went_down;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ecp_capture.sv
module ecp_capture #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [WIDTH-1:0] timer_val,
  output logic [WIDTH-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (hit) value <= timer_val;
  end

endmodule

// File: rtl/ecp_ctrl_reg.sv
module ecp_ctrl_reg
  import ecp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic              rmw,
  input  logic [7:0]        wdata,
  input  logic [NUM_CH-1:0] hit,
  output ctrl_byte_t        ctrl_q,
  output logic [7:0]        rdata
);

  ctrl_byte_t wr_view;
  ctrl_byte_t rd_view;

  assign wr_view = ctrl_byte_t'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_sel) begin
        ctrl_q.en    <= wr_view.en;
        ctrl_q.mode1 <= wr_view.mode1;
        ctrl_q.mode0 <= wr_view.mode0;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        // Hardware set dominates a software clear in the same cycle.
        ctrl_q.flag[i] <= hit[i] |
                          (ctrl_q.flag[i] & ~(wr_sel & ~wr_view.flag[i]));
      end
    end
  end

  always_comb begin
    rd_view = ctrl_q;
    if (rmw) rd_view.flag = '1;
    rdata = rd_sel ? 8'(rd_view) : 8'h00;
  end

endmodule

// File: rtl/edge_capture_pair.sv
module edge_capture_pair
  import ecp_pkg::*;
#(
  parameter int              TIMER_W     = 16,
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  input  logic               reg_rmw,
  output logic [7:0]         reg_rdata,
  input  logic [1:0]         cap_pin,
  input  logic [TIMER_W-1:0] timer_val,
  output logic [TIMER_W-1:0] cap_data0,
  output logic [TIMER_W-1:0] cap_data1,
  output logic [1:0]         irq
);

  localparam int NCH = NUM_CH;

  logic               rd_sel;
  logic               wr_sel;
  ctrl_byte_t         ctrl_q;
  logic [NCH-1:0]     flag_vec;
  logic [NCH-1:0]     en_vec;
  logic [NCH-1:0]     hit;
  logic [NCH-1:0]     lvl;
  logic [NCH-1:0]     lvl_d;
  edge_mode_e         mode_vec [NCH];
  logic [TIMER_W-1:0] cap_q    [NCH];

  assign rd_sel = (reg_addr == CTRL_ADDR);
  assign wr_sel = rd_sel & reg_wr;

  ecp_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel),
    .rmw    (reg_rmw),
    .wdata  (reg_wdata),
    .hit    (hit),
    .ctrl_q (ctrl_q),
    .rdata  (reg_rdata)
  );

  assign flag_vec    = ctrl_q.flag;
  assign en_vec      = ctrl_q.en;
  assign mode_vec[0] = ctrl_q.mode0;
  assign mode_vec[1] = ctrl_q.mode1;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      ecp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_pin[c]),
        .level   (lvl[c]),
        .level_d (lvl_d[c])
      );

      ecp_edge_detect u_det (
        .level   (lvl[c]),
        .level_d (lvl_d[c]),
        .mode    (mode_vec[c]),
        .hit     (hit[c])
      );

      ecp_capture #(.WIDTH(TIMER_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit[c]),
        .timer_val (timer_val),
        .value     (cap_q[c])
      );
    end
  endgenerate

  assign cap_data0 = cap_q[0];
  assign cap_data1 = cap_q[1];
  assign irq       = flag_vec & en_vec;

endmodule

// File: rtl/ecp_checker.sv
module ecp_checker #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_sel,
  input logic               rd_sel,
  input logic               reg_rmw,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic [1:0]         hit,
  input logic [1:0]         flag,
  input logic [1:0]         en,
  input logic [1:0]         irq,
  input logic [TIMER_W-1:0] timer_val,
  input logic [TIMER_W-1:0] cap0,
  input logic [TIMER_W-1:0] cap1
);

  generate
    for (genvar i = 0; i < 2; i++) begin : g_chk
      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flag[i] && !(wr_sel && !reg_wdata[6+i]) |=> flag[i]); // R7
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |=> flag[i]); // R9
      AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[i]) |-> $past(hit[i])); // R2
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq[i] |-> (en[i] && flag[i])); // R11
    end
  endgenerate

  AST_CAPTURE0: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> cap0 == $past(timer_val)); // R6
  AST_CAPTURE1: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> cap1 == $past(timer_val)); // R6
  AST_CAP_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
    !hit[0] |=> $stable(cap0)); // R6
  AST_CAP_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit[1] |=> $stable(cap1)); // R6
  AST_RMW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && reg_rmw) |-> reg_rdata[7:6] == 2'b11); // R10

endmodule

bind edge_capture_pair ecp_checker #(.TIMER_W(TIMER_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_sel    (wr_sel),
  .rd_sel    (rd_sel),
  .reg_rmw   (reg_rmw),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .hit       (hit),
  .flag      (flag_vec),
  .en        (en_vec),
  .irq       (irq),
  .timer_val (timer_val),
  .cap0      (cap_data0),
  .cap1      (cap_data1)
);

// File: tb/edge_capture_pair_test.sv
module edge_capture_pair_test;

  localparam int TW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic          reg_rmw = 1'b0;
  logic [7:0]    reg_rdata;
  logic [1:0]    cap_pin = '0;
  logic [TW-1:0] timer_val = '0;
  logic [TW-1:0] cap_data0;
  logic [TW-1:0] cap_data1;
  logic [1:0]    irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  edge_capture_pair #(.TIMER_W(TW), .SYNC_STAGES(2), .ADDR_W(AW), .CTRL_ADDR('0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rmw(reg_rmw), .reg_rdata(reg_rdata),
    .cap_pin(cap_pin), .timer_val(timer_val), .cap_data0(cap_data0),
    .cap_data1(cap_data1), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic rmw, output logic [7:0] d);
    reg_addr = a; reg_rmw = rmw;
    #1 d = reg_rdata;
    reg_rmw = 1'b0; reg_addr = '0;
  endtask

  task automatic drive_pin(input int ch, input logic v, input logic [TW-1:0] t);
    timer_val = t;
    cap_pin[ch] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd('0, 1'b0, d);
    check("R1 ctrl", d, 8'h00);
    check("R1 irq", irq, 2'b00);
    check("R1 cap0", cap_data0, 0);
    check("R1 cap1", cap_data1, 0);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr('0, 8'h3F); rd('0, 1'b0, d);
    check("R8 fields", d, 8'h3F);
    wr('0, 8'hFF); rd('0, 1'b0, d);
    check("R7 write1 no set", d, 8'h3F);
    check("R7 irq idle", irq, 2'b00);
    wr('0, 8'h00); rd('0, 1'b0, d);
    check("R8 cleared", d, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    wr('0, 8'h11);
    timer_val = 16'h1234;
    cap_pin[0] = 1'b1;
    repeat (2) @(posedge clk);
    #1 rd('0, 1'b0, d);
    check("R12 not yet", d, 8'h11);
    @(posedge clk);
    #1 rd('0, 1'b0, d);
    check("R12 flag on 3rd edge", d, 8'h51);
    @(negedge clk);
    check("R6 cap0", cap_data0, 16'h1234);
    check("R11 irq0", irq, 2'b01);
    drive_pin(0, 1'b0, 16'h5555);
    check("R2 fall ignored cap", cap_data0, 16'h1234);
    wr('0, 8'h11); rd('0, 1'b0, d);
    check("R7 clear", d, 8'h11);
    check("R7 irq off", irq, 2'b00);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    wr('0, 8'h28);
    drive_pin(1, 1'b1, 16'd7);
    rd('0, 1'b0, d);
    check("R3 rise ignored", d, 8'h28);
    drive_pin(1, 1'b0, 16'd99);
    rd('0, 1'b0, d);
    check("R3 fall flag", d, 8'hA8);
    check("R3 cap1", cap_data1, 16'd99);
    check("R11 irq1", irq, 2'b10);
    wr('0, 8'h28);
  endtask

  task automatic t_both();
    logic [7:0] d;
    wr('0, 8'h03);
    drive_pin(0, 1'b1, 16'd10);
    rd('0, 1'b0, d);
    check("R4 rise flag", d, 8'h43);
    check("R11 masked", irq, 2'b00);
    check("R4 cap rise", cap_data0, 16'd10);
    drive_pin(0, 1'b0, 16'd20);
    check("R6 overwrite", cap_data0, 16'd20);
    rd('0, 1'b1, d);
    check("R10 rmw read", d, 8'hC3);
    wr('0, d | 8'h10);
    rd('0, 1'b0, d);
    check("R10 true read", d, 8'h53);
    check("R11 unmasked", irq, 2'b01);
    wr('0, 8'h13);
  endtask

  task automatic t_off();
    logic [7:0] d;
    wr('0, 8'h00);
    drive_pin(1, 1'b1, 16'd77);
    drive_pin(1, 1'b0, 16'd78);
    rd('0, 1'b0, d);
    check("R5 no flag", d, 8'h00);
    check("R5 cap held", cap_data1, 16'd99);
  endtask

  task automatic t_mode_change();
    logic [7:0] d;
    drive_pin(0, 1'b1, 16'd1);
    wr('0, 8'h01);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd('0, 1'b0, d);
    check("R12 no spurious rise", d, 8'h01);
    wr('0, 8'h02);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd('0, 1'b0, d);
    check("R12 no spurious mode2", d, 8'h02);
    drive_pin(0, 1'b0, 16'd3);
    rd('0, 1'b0, d);
    check("R3 real fall", d, 8'h42);
    wr('0, 8'h11);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    timer_val = 16'h0ABC;
    cap_pin[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_addr = '0; reg_wdata = 8'h11; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    rd('0, 1'b0, d);
    check("R9 set wins", d, 8'h51);
    check("R9 cap", cap_data0, 16'h0ABC);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    wr(4'd1, 8'h00);
    rd('0, 1'b0, d);
    check("R13 other write", d, 8'h51);
    rd(4'd1, 1'b0, d);
    check("R13 other read", d, 8'h00);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_mode_change();
    t_set_wins();
    t_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule